// File: doc/BRIEF.md
# Periodic Transmit Time-Slice Gate

This block decides, frame by frame, whether a wireless MAC may start a transmission now. Airtime is shared between two destinations. Each destination is served by its own time slice: a repeating cycle with a programmable period and an active window inside that period. Every slice also holds a 32-bit destination tag. The tag is the low 32 bits of a 48-bit station address. For example, station 6c:fd:b9:4c:b1:c1 is written as 0xb94cb1c1.

The queue presents the low 32 bits of the destination address of the frame at its head. When the tag matches a slice, the grant follows that slice's window. When the tag matches no slice, the frame is always allowed. All time values count microseconds and are written as "value minus one" where the value is a length or an end point. A 50 ms cycle is therefore written as 49999, and a window ending at 40 ms is written as 39999. A start at 10 ms is written as 10000. A prescaler derives the microsecond tick from the system clock, and its ratio is set by the clock-frequency parameter.

Configuration arrives on a one-cycle write strobe with an address and a data word. Writing a slice's cycle length restarts that slice's cycle.

Top module: `txslice_gate`

## Requirements
- R1: There are two slices, and each one has its own counter and its own configuration. The write address is {slice index in bit 2, field in bits 1:0}. The field codes are 0 for the cycle length, 1 for the start, 2 for the end and 3 for the destination tag. A write to one slice never changes the other slice's window.
- R2: After reset, every field and both counters are zero. Both windows are therefore open, and grant_o is 1 for any tag.
- R3: A microsecond tick occurs once every CLK_FREQ_HZ/1,000,000 clocks. Each tick advances a slice counter by one. The counter steps from its cycle-length value back to 0, so the period is (cycle + 1) µs.
- R4: window_o[s] is 1 while start <= count <= end. The window is therefore open for (end - start + 1) µs in each period. If start > end, the window never opens. An end value above the cycle length is effectively clamped to the cycle length.
- R5: A write to a cycle-length field clears that slice's counter at the same clock edge. Writes to the start, end or tag fields leave the counter running.
- R6: grant_o is combinational from frame_tag_i. If the tag equals a slice's tag, grant_o equals that slice's window. If the tag matches no slice, grant_o is 1.
- R7: If the tag matches both slices, slice 0 alone decides grant_o.
- R8: After a cycle-length write, a slice whose start is N > 0 first opens between (N - 1) and N µs after the write. The exact point depends on the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_addr_i | input | 3 | Write address: {slice, field} |
| wr_data_i | input | 32 | Write data |
| frame_tag_i | input | 32 | Low 32 bits of the head frame's destination address |
| grant_o | output | 1 | Transmission of the head frame is allowed |
| window_o | output | 2 | Per-slice window-open status |

## Verification
The bench builds the block with CLK_FREQ_HZ set to 4 MHz, so one microsecond lasts four clocks. With this setting, whole periods of 10 to 20 µs run in under a hundred clocks. This makes exact open-time totals, period spacing and the first-opening bound after a cycle write cheap to measure. The totals are counted over exactly one period, which makes them independent of the prescaler phase. The grant decode is exercised with configurations where a window is held permanently open (cycle, start and end all zero) or permanently shut (start > end). This setup lets the matching and priority cases be checked with no dependence on timing.

// File: rtl/txslice_pkg.sv
package txslice_pkg;

  localparam int NUM_SLICES = 2;
  localparam int TIME_W     = 32;
  localparam int TAG_W      = 32;
  localparam int DATA_W     = 32;
  localparam int FIELD_W    = 2;
  localparam int SEL_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
  localparam int WADDR_W    = SEL_W + FIELD_W;
  localparam int US_HZ      = 1_000_000;

  typedef enum logic [FIELD_W-1:0] {
    FLD_CYCLE = 2'd0,
    FLD_START = 2'd1,
    FLD_END   = 2'd2,
    FLD_TAG   = 2'd3
  } field_e;

  typedef struct packed {
    logic [TIME_W-1:0] cycle;
    logic [TIME_W-1:0] start;
    logic [TIME_W-1:0] last;
    logic [TAG_W-1:0]  tag;
  } slice_cfg_t;

endpackage

// File: rtl/ts_tick_gen.sv
module ts_tick_gen
  import txslice_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CLKS_PER_US = CLK_FREQ_HZ / US_HZ;

  generate
    if (CLKS_PER_US <= 1) begin : g_every_clk
      assign tick_o = 1'b1;
    end else begin : g_prescale
      localparam int PRE_W = $clog2(CLKS_PER_US);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

      logic [PRE_W-1:0] pre_q;
      logic [PRE_W-1:0] pre_d;
      logic             pre_wrap;

      assign pre_wrap = (pre_q == PRE_LAST);

      always_comb begin
        if (pre_wrap) pre_d = '0;
        else          pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick_o = pre_wrap;
    end
  endgenerate

endmodule

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
  import txslice_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic [WADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output slice_cfg_t [NUM_SLICES-1:0]     cfg_o,
  output logic [NUM_SLICES-1:0]           cyc_wr_o
);

  field_e            fld;
  logic [SEL_W-1:0]  sel;

  assign fld = field_e'(wr_addr_i[FIELD_W-1:0]);
  assign sel = wr_addr_i[WADDR_W-1:FIELD_W];

  genvar s;
  generate
    for (s = 0; s < NUM_SLICES; s++) begin : g_slice
      slice_cfg_t cfg_q;
      slice_cfg_t cfg_d;
      logic       hit;
      logic       en_cycle;
      logic       en_start;
      logic       en_end;
      logic       en_tag;

      assign hit      = wr_en_i && (sel == SEL_W'(s));
      assign en_cycle = hit && (fld == FLD_CYCLE);
      assign en_start = hit && (fld == FLD_START);
      assign en_end   = hit && (fld == FLD_END);
      assign en_tag   = hit && (fld == FLD_TAG);

      always_comb begin
        cfg_d = cfg_q;
        if (en_cycle) cfg_d.cycle = TIME_W'(wr_data_i);
        if (en_start) cfg_d.start = TIME_W'(wr_data_i);
        if (en_end)   cfg_d.last  = TIME_W'(wr_data_i);
        if (en_tag)   cfg_d.tag   = TAG_W'(wr_data_i);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else if (hit) cfg_q <= cfg_d;
      end

      assign cfg_o[s]    = cfg_q;
      assign cyc_wr_o[s] = en_cycle;
    end
  endgenerate

endmodule

// File: rtl/ts_slice_timer.sv
module ts_slice_timer
  import txslice_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              clear_i,
  input  logic [TIME_W-1:0] cycle_i,
  input  logic [TIME_W-1:0] start_i,
  input  logic [TIME_W-1:0] last_i,
  output logic [TIME_W-1:0] cnt_o,
  output logic              open_o
);

  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] cnt_d;
  logic              cnt_en;
  logic              at_end;

  assign at_end = (cnt_q >= cycle_i);
  assign cnt_en = clear_i || tick_i;

  always_comb begin
    if (clear_i)     cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign open_o = (cnt_q >= start_i) && (cnt_q <= last_i);

endmodule

// File: rtl/ts_grant_sel.sv
module ts_grant_sel
  import txslice_pkg::*;
(
  input  logic [TAG_W-1:0]            tag_i,
  input  slice_cfg_t [NUM_SLICES-1:0] cfg_i,
  input  logic [NUM_SLICES-1:0]       open_i,
  output logic                        grant_o
);

  logic [NUM_SLICES-1:0] match;

  genvar s;
  generate
    for (s = 0; s < NUM_SLICES; s++) begin : g_match
      assign match[s] = (tag_i == cfg_i[s].tag);
    end
  endgenerate

  always_comb begin
    grant_o = 1'b1;
    for (int i = NUM_SLICES - 1; i >= 0; i--) begin
      if (match[i]) grant_o = open_i[i];
    end
  end

endmodule

// File: rtl/txslice_gate.sv
module txslice_gate
  import txslice_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [WADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [TAG_W-1:0]   frame_tag_i,
  output logic               grant_o,
  output logic [NUM_SLICES-1:0] window_o
);

  logic                                tick;
  slice_cfg_t [NUM_SLICES-1:0]         cfg;
  logic [NUM_SLICES-1:0]               cyc_wr;
  logic [NUM_SLICES-1:0][TIME_W-1:0]   cnt;

  ts_tick_gen #(
    .CLK_FREQ_HZ (CLK_FREQ_HZ)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  ts_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .cyc_wr_o  (cyc_wr)
  );

  genvar s;
  generate
    for (s = 0; s < NUM_SLICES; s++) begin : g_timer
      ts_slice_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .clear_i (cyc_wr[s]),
        .cycle_i (cfg[s].cycle),
        .start_i (cfg[s].start),
        .last_i  (cfg[s].last),
        .cnt_o   (cnt[s]),
        .open_o  (window_o[s])
      );
    end
  endgenerate

  ts_grant_sel u_grant (
    .tag_i   (frame_tag_i),
    .cfg_i   (cfg),
    .open_i  (window_o),
    .grant_o (grant_o)
  );

endmodule

// File: rtl/txslice_gate_chk.sv
module txslice_gate_chk
  import txslice_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              tick,
  input logic [NUM_SLICES-1:0]             cyc_wr,
  input logic [NUM_SLICES-1:0][TIME_W-1:0] cnt,
  input slice_cfg_t [NUM_SLICES-1:0]       cfg,
  input logic [TAG_W-1:0]                  frame_tag,
  input logic                              grant,
  input logic [NUM_SLICES-1:0]             window
);

  localparam int CLKS_PER_US = CLK_FREQ_HZ / US_HZ;

  logic [NUM_SLICES-1:0] tag_hit;

  genvar s;
  generate
    for (s = 0; s < NUM_SLICES; s++) begin : g_chk
      assign tag_hit[s] = (frame_tag == cfg[s].tag);

      // R5: a cycle-length write restarts that slice
      a_r5_cycle_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_wr[s] |=> (cnt[s] == '0));

      // R1, R3: without a tick or own cycle write the counter holds
      a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cyc_wr[s]) |=> $stable(cnt[s]));

      // R3: the counter never runs past the programmed cycle length
      a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[s] <= cfg[s].cycle);

      // R4: an inverted window never opens
      a_r4_inverted_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[s].start > cfg[s].last) |-> !window[s]);
    end

    if (CLKS_PER_US > 1) begin : g_tick_chk
      // R3: ticks are spaced apart by the prescaler
      a_r3_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

  // R6: a tag that matches no slice is always granted
  a_r6_unmatched_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_hit == '0) |-> grant);

  // R7: slice 0 decides whenever its tag matches
  a_r7_slice0_priority: assert property (@(posedge clk) disable iff (!rst_n)
    tag_hit[0] |-> (grant == window[0]));

endmodule

bind txslice_gate txslice_gate_chk #(
  .CLK_FREQ_HZ (CLK_FREQ_HZ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .cyc_wr    (cyc_wr),
  .cnt       (cnt),
  .cfg       (cfg),
  .frame_tag (frame_tag_i),
  .grant     (grant_o),
  .window    (window_o)
);

// File: tb/sim_txslice_gate.sv
`timescale 1ns/1ps
module sim_txslice_gate;
  import txslice_pkg::*;

  localparam int CLK_HZ = 4_000_000;
  localparam int K      = 4;
  localparam logic [31:0] TAG_A = 32'hb94c_b1c1;
  localparam logic [31:0] TAG_B = 32'h0000_1234;
  localparam logic [31:0] TAG_C = 32'h5a5a_0f0f;

  // {tag, expected grant}: slice 0 = TAG_A always open, slice 1 = TAG_B never open
  localparam logic [32:0] VEC [0:5] = '{
    {TAG_A, 1'b1},
    {TAG_B, 1'b0},
    {32'h0000_0000, 1'b1},
    {TAG_A ^ 32'h1, 1'b1},
    {TAG_B ^ 32'h8000_0000, 1'b1},
    {32'hffff_ffff, 1'b1}
  };

  logic                  clk;
  logic                  rst_n;
  logic                  wr_en;
  logic [WADDR_W-1:0]    wr_addr;
  logic [DATA_W-1:0]     wr_data;
  logic [TAG_W-1:0]      tag;
  logic                  grant;
  logic [NUM_SLICES-1:0] win;

  int n_chk = 0;
  int n_bad = 0;

  txslice_gate #(.CLK_FREQ_HZ(CLK_HZ)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .frame_tag_i (tag),
    .grant_o     (grant),
    .window_o    (win)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic expect_eq(input string req, input string what,
                           input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_in(input string req, input string what,
                           input longint act, input longint lo, input longint hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wr_reg(input int s, input field_e f, input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = {SEL_W'(s), f};
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic cfg_slice(input int s, input logic [31:0] cyc, input logic [31:0] st,
                           input logic [31:0] en, input logic [31:0] tg);
    wr_reg(s, FLD_TAG, tg);
    wr_reg(s, FLD_START, st);
    wr_reg(s, FLD_END, en);
    wr_reg(s, FLD_CYCLE, cyc);
  endtask

  task automatic count_open(input int s, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (win[s]) c++;
    end
  endtask

  task automatic wait_rise(input int s, output int n);
    n = 0;
    while (win[s]) begin @(negedge clk); n++; end
    while (!win[s]) begin @(negedge clk); n++; end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: cycles %0d expected below %0d", 50000, 50000);
    summary();
    $finish;
  end

  initial begin
    int c;
    int n;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    tag     = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state, everything zero, both windows open
    expect_eq("R2", "window after reset", win, 2'b11);
    tag = TAG_C; #1;
    expect_eq("R2", "grant after reset", grant, 1);

    // R6: vector table for the tag decode
    cfg_slice(0, 0, 0, 0, TAG_A);
    cfg_slice(1, 7, 5, 2, TAG_B);
    for (int i = 0; i < 6; i++) begin
      tag = VEC[i][32:1]; #1;
      expect_eq("R6", $sformatf("grant vector %0d", i), grant, VEC[i][0]);
    end

    // R6: shut slice 0 by writing start > end
    wr_reg(0, FLD_START, 1);
    tag = TAG_A; #1;
    expect_eq("R6", "grant with slice 0 shut", grant, 0);

    // R7: both tags equal, slice 0 shut and slice 1 open
    cfg_slice(1, 0, 0, 0, TAG_A);
    tag = TAG_A; #1;
    expect_eq("R7", "window slice 1 open", win[1], 1);
    expect_eq("R7", "slice 0 decides (shut)", grant, 0);
    wr_reg(0, FLD_START, 0);
    wr_reg(1, FLD_START, 1);
    tag = TAG_A; #1;
    expect_eq("R7", "slice 0 decides (open)", grant, 1);

    // R4, R8: window 4..6 in a 20 us cycle
    cfg_slice(0, 19, 4, 6, TAG_A);
    expect_eq("R5", "closed right after cycle write", win[0], 0);
    wait_rise(0, n);
    expect_in("R8", "clocks to first opening", n, 3*K + 1, 4*K);
    count_open(0, 20*K, c);
    expect_eq("R4", "open clocks per period 4..6", c, 3*K);

    // R4: inverted window
    cfg_slice(0, 19, 6, 4, TAG_A);
    count_open(0, 20*K, c);
    expect_eq("R4", "open clocks inverted window", c, 0);

    // R4: end beyond cycle clamps
    cfg_slice(0, 9, 2, 50, TAG_A);
    count_open(0, 10*K, c);
    expect_eq("R4", "open clocks end beyond cycle", c, 8*K);

    // R3: period of a 10 us cycle
    cfg_slice(0, 9, 0, 0, TAG_A);
    wait_rise(0, n);
    wait_rise(0, n);
    expect_eq("R3", "clocks between openings", n, 10*K);
    wait_rise(0, n);
    expect_eq("R3", "clocks between openings again", n, 10*K);
    count_open(0, 10*K, c);
    expect_eq("R3", "one microsecond open per period", c, K);

    // R5, R1: counter restart only on cycle writes, and only for that slice
    cfg_slice(1, 99, 0, 0, TAG_B);
    expect_eq("R5", "slice 1 open after cycle write", win[1], 1);
    cfg_slice(0, 99, 0, 1, TAG_A);
    expect_eq("R5", "slice 0 open after cycle write", win[0], 1);
    repeat (3*K) @(negedge clk);
    expect_eq("R3", "slice 0 closed after 3 us", win[0], 0);
    expect_eq("R3", "slice 1 closed later", win[1], 0);
    wr_reg(0, FLD_START, 0);
    expect_eq("R5", "start write keeps counter", win[0], 0);
    wr_reg(0, FLD_TAG, TAG_A);
    expect_eq("R5", "tag write keeps counter", win[0], 0);
    wr_reg(0, FLD_CYCLE, 99);
    expect_eq("R5", "cycle rewrite reopens slice 0", win[0], 1);
    expect_eq("R1", "slice 1 untouched by slice 0 write", win[1], 0);
    tag = TAG_B; #1;
    expect_eq("R6", "grant follows closed slice 1", grant, 0);

    summary();
    $finish;
  end

endmodule